// File: doc/BRIEF.md
# Block Bit-Plane Set-Partitioning Encoder

This block codes one 8×8 block of wavelet coefficients into a serial bit stream, one bit plane at a time from plane 7 down to plane 0. Coefficients are stored in sign-magnitude form with an 8-bit magnitude. Each plane is walked in Z-curve order without any lists. At each step the encoder either tests a set (a 4×4 quadrant or a 2×2 quad), codes a pixel that is still insignificant, or emits a refinement bit for a pixel that is already known to be significant. Each coefficient has one significance flag. The flags replace the linked lists of the classic algorithm.

A host writes the 64 coefficients through a simple write port and pulses `start`. Bits leave on `bit_out`, and each one is qualified by `bit_valid`. `done` rises once the last bit of plane 0 has been sent. If every coefficient is significant at the end of a plane, all later planes skip set testing and emit one refinement bit per cycle.

The control is a single state machine with these states:
- ST_IDLE: waits after reset.
- ST_SET4: tests a 4×4 quadrant.
- ST_SET2: tests a 2×2 quad.
- ST_PIX: codes one pixel, either a significance bit or a refinement bit.
- ST_SIGN: emits the sign of a pixel that has just become significant.
- ST_REF: refinement-only mode.
- ST_DONE: holds `done`.

The transitions are:
- ST_IDLE or ST_DONE go to ST_SET4 on an accepted start.
- ST_SET4 goes to ST_SET2, and ST_SET2 goes to ST_PIX, when the set is split.
- ST_PIX goes to ST_SIGN on a new significance.
- Any step that advances the index goes to ST_SET4, ST_SET2 or ST_PIX, chosen by the alignment of the new index.
- At the end of a plane the machine goes to ST_SET4 or ST_REF for the next plane, or to ST_DONE after plane 0.

Top module: `spiht_block_encoder`

## Requirements
- R1: A write stores `wr_data` at raster address `wr_addr`, where address bits [5:3] are the row and bits [2:0] are the column. Bit 8 of the data is the sign (1 means negative) and bits [7:0] are the magnitude. Writes are accepted only in ST_IDLE or ST_DONE. A write made while encoding changes neither the current stream nor the stored block.
- R2: An accepted `start` clears all significance flags and begins at plane 7. A `start` made while encoding is ignored.
- R3: Each plane is walked in Z-curve order. Quadrants are visited top-left, top-right, bottom-left, bottom-right at every level: the 4×4 quadrants first, then the 2×2 quads inside them, then the pixels inside those.
- R4: A set that holds no significant pixel emits one bit, which is 1 when any of its magnitudes has bit n set. A 0 skips the whole set for that plane. A 1 splits the set.
- R5: A set that already holds a significant pixel emits no bit and is split directly.
- R6: An insignificant pixel emits 0 when its magnitude bit n is clear. When the bit is set, it emits 1 and then its sign bit, and the pixel becomes significant.
- R7: A pixel that became significant in an earlier plane emits its magnitude bit n.
- R8: If all 64 pixels are significant when a plane ends, every later plane emits exactly 64 refinement bits in consecutive cycles.
- R9: After reset, `bit_valid` and `done` are low. `done` rises the cycle after the last valid bit and stays high, with `bit_valid` low, until the cycle after the next accepted start.
- R10: An all-zero block produces exactly 32 zero bits, four per plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | 6 | Raster address {row, column} |
| wr_data | input | 9 | {sign, magnitude[7:0]} |
| start | input | 1 | Begin encoding the stored block |
| bit_out | output | 1 | Stream bit |
| bit_valid | output | 1 | `bit_out` carries a stream bit |
| done | output | 1 | Block fully emitted |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose.

The first pair is the sign emission of the last Z-curve pixel and the end-of-plane decision between ST_SET4 and ST_REF. That decision depends on a flag that is being set in that very cycle. A block whose magnitudes all reach 128 makes pixel 63 the last one to turn significant in plane 7. The check is that the following 448 bits arrive in consecutive cycles and match the model.

The second pair is a host `start` and write arriving during an active encode. The check is that the stream stays bit-identical to the model, and that a rerun without reloading produces the same stream again.

// File: rtl/spiht_pkg.sv
package spiht_pkg;

    localparam int MAG_BITS  = 8;
    localparam int DIM_LOG   = 3;
    localparam int IDX_W     = 2 * DIM_LOG;
    localparam int NCOEF     = 1 << IDX_W;
    localparam int COEF_W    = MAG_BITS + 1;
    localparam int PLANE_W   = $clog2(MAG_BITS);
    localparam int BIG_LOG   = 2 * (DIM_LOG - 1);
    localparam int SMALL_LOG = 2 * (DIM_LOG - 2);
    localparam int BIG_SPAN  = 1 << BIG_LOG;
    localparam int SMALL_SPAN = 1 << SMALL_LOG;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET4,
        ST_SET2,
        ST_PIX,
        ST_SIGN,
        ST_REF,
        ST_DONE
    } enc_state_e;

    // Interleave row and column bits: column bit k -> z[2k], row bit k -> z[2k+1]
    function automatic logic [IDX_W-1:0] raster_to_z(input logic [IDX_W-1:0] a);
        logic [IDX_W-1:0] z;
        for (int k = 0; k < DIM_LOG; k++) begin
            z[2*k]   = a[k];
            z[2*k+1] = a[DIM_LOG+k];
        end
        return z;
    endfunction

endpackage

// File: rtl/spiht_coef_bank.sv
module spiht_coef_bank
    import spiht_pkg::*;
(
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [COEF_W-1:0]  wr_data,
    input  logic [PLANE_W-1:0] plane,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [NCOEF-1:0]   plane_bits,
    output logic               rd_bit,
    output logic               rd_sign
);

    logic [MAG_BITS-1:0] mag_q  [NCOEF];
    logic                sign_q [NCOEF];
    logic [IDX_W-1:0]    wr_z;

    assign wr_z = raster_to_z(wr_addr);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mag_q[wr_z]  <= wr_data[MAG_BITS-1:0];
            sign_q[wr_z] <= wr_data[MAG_BITS];
        end
    end

    for (genvar i = 0; i < NCOEF; i++) begin : g_slice
        assign plane_bits[i] = mag_q[i][plane];
    end

    assign rd_bit  = plane_bits[rd_idx];
    assign rd_sign = sign_q[rd_idx];

endmodule

// File: rtl/spiht_sig_flags.sv
module spiht_sig_flags
    import spiht_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [NCOEF-1:0] flags,
    output logic             all_now,
    output logic             all_next
);

    logic [NCOEF-1:0] set_mask;

    assign set_mask = set_en ? ({{(NCOEF-1){1'b0}}, 1'b1} << set_idx) : '0;
    assign all_now  = &flags;
    assign all_next = &(flags | set_mask);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags <= '0;
        end else if (set_en) begin
            flags <= flags | set_mask;
        end
    end

endmodule

// File: rtl/spiht_set_probe.sv
module spiht_set_probe
    import spiht_pkg::*;
(
    input  logic [NCOEF-1:0] flags,
    input  logic [NCOEF-1:0] plane_bits,
    input  logic [IDX_W-1:0] idx,
    output logic             big_flag,
    output logic             big_hit,
    output logic             small_flag,
    output logic             small_hit
);

    localparam int NBIG   = NCOEF / BIG_SPAN;
    localparam int NSMALL = NCOEF / SMALL_SPAN;

    logic [NBIG-1:0]   bf, bh;
    logic [NSMALL-1:0] sf, sh;

    for (genvar g = 0; g < NBIG; g++) begin : g_big
        assign bf[g] = |flags[g*BIG_SPAN +: BIG_SPAN];
        assign bh[g] = |plane_bits[g*BIG_SPAN +: BIG_SPAN];
    end

    for (genvar q = 0; q < NSMALL; q++) begin : g_small
        assign sf[q] = |flags[q*SMALL_SPAN +: SMALL_SPAN];
        assign sh[q] = |plane_bits[q*SMALL_SPAN +: SMALL_SPAN];
    end

    assign big_flag   = bf[idx[IDX_W-1:BIG_LOG]];
    assign big_hit    = bh[idx[IDX_W-1:BIG_LOG]];
    assign small_flag = sf[idx[IDX_W-1:SMALL_LOG]];
    assign small_hit  = sh[idx[IDX_W-1:SMALL_LOG]];

endmodule

// File: rtl/spiht_block_encoder.sv
module spiht_block_encoder
    import spiht_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic              start,
    output logic              bit_out,
    output logic              bit_valid,
    output logic              done
);

    localparam logic [IDX_W:0]   STEP_BIG   = (IDX_W+1)'(BIG_SPAN);
    localparam logic [IDX_W:0]   STEP_SMALL = (IDX_W+1)'(SMALL_SPAN);
    localparam logic [IDX_W:0]   STEP_ONE   = (IDX_W+1)'(1);
    localparam logic [PLANE_W-1:0] PLANE_TOP = PLANE_W'(MAG_BITS-1);
    localparam logic [PLANE_W-1:0] PLANE_ONE = PLANE_W'(1);

    enc_state_e         state_q, nxt;
    logic [IDX_W-1:0]   idx_q, idx_n;
    logic [PLANE_W-1:0] plane_q, plane_n;
    logic               go, idle_like, accept_wr;
    logic [NCOEF-1:0]   plane_bits, flags;
    logic               pix_bit, pix_sign, pix_flag;
    logic               big_flag, big_hit, small_flag, small_hit;
    logic               all_now, all_next;
    logic               emit, ebit, set_en, clr, adv;
    logic [IDX_W:0]     step, idx_sum;

    assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign go        = start && idle_like;
    assign accept_wr = wr_en && idle_like;
    assign pix_flag  = flags[idx_q];

    spiht_coef_bank u_bank (
        .clk        (clk),
        .wr_en      (accept_wr),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .plane      (plane_q),
        .rd_idx     (idx_q),
        .plane_bits (plane_bits),
        .rd_bit     (pix_bit),
        .rd_sign    (pix_sign)
    );

    spiht_sig_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .set_en   (set_en),
        .set_idx  (idx_q),
        .flags    (flags),
        .all_now  (all_now),
        .all_next (all_next)
    );

    spiht_set_probe u_probe (
        .flags      (flags),
        .plane_bits (plane_bits),
        .idx        (idx_q),
        .big_flag   (big_flag),
        .big_hit    (big_hit),
        .small_flag (small_flag),
        .small_hit  (small_hit)
    );

    // Next-state and emission decision
    always_comb begin
        nxt     = state_q;
        idx_n   = idx_q;
        plane_n = plane_q;
        emit    = 1'b0;
        ebit    = 1'b0;
        set_en  = 1'b0;
        clr     = 1'b0;
        adv     = 1'b0;
        step    = '0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (go) begin
                    clr     = 1'b1;
                    idx_n   = '0;
                    plane_n = PLANE_TOP;
                    nxt     = ST_SET4;
                end
            end
            ST_SET4: begin
                if (big_flag) begin
                    nxt = ST_SET2;
                end else begin
                    emit = 1'b1;
                    ebit = big_hit;
                    if (big_hit) begin
                        nxt = ST_SET2;
                    end else begin
                        adv  = 1'b1;
                        step = STEP_BIG;
                    end
                end
            end
            ST_SET2: begin
                if (small_flag) begin
                    nxt = ST_PIX;
                end else begin
                    emit = 1'b1;
                    ebit = small_hit;
                    if (small_hit) begin
                        nxt = ST_PIX;
                    end else begin
                        adv  = 1'b1;
                        step = STEP_SMALL;
                    end
                end
            end
            ST_PIX: begin
                emit = 1'b1;
                ebit = pix_bit;
                if (!pix_flag && pix_bit) begin
                    nxt = ST_SIGN;
                end else begin
                    adv  = 1'b1;
                    step = STEP_ONE;
                end
            end
            ST_SIGN: begin
                emit   = 1'b1;
                ebit   = pix_sign;
                set_en = 1'b1;
                adv    = 1'b1;
                step   = STEP_ONE;
            end
            ST_REF: begin
                emit = 1'b1;
                ebit = pix_bit;
                adv  = 1'b1;
                step = STEP_ONE;
            end
            default: nxt = ST_IDLE;
        endcase

        idx_sum = {1'b0, idx_q} + step;

        if (adv) begin
            if (idx_sum[IDX_W]) begin
                idx_n = '0;
                if (plane_q == '0) begin
                    nxt = ST_DONE;
                end else begin
                    plane_n = plane_q - PLANE_ONE;
                    nxt     = all_next ? ST_REF : ST_SET4;
                end
            end else begin
                idx_n = idx_sum[IDX_W-1:0];
                if (state_q == ST_REF) begin
                    nxt = ST_REF;
                end else if (idx_sum[BIG_LOG-1:0] == '0) begin
                    nxt = ST_SET4;
                end else if (idx_sum[SMALL_LOG-1:0] == '0) begin
                    nxt = ST_SET2;
                end else begin
                    nxt = ST_PIX;
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            plane_q <= '0;
        end else begin
            state_q <= nxt;
            idx_q   <= idx_n;
            plane_q <= plane_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            bit_out   <= ebit;
            bit_valid <= emit;
            done      <= (state_q == ST_DONE) && !go;
        end
    end

endmodule

// File: rtl/spiht_encoder_checker.sv
module spiht_encoder_checker
    import spiht_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bit_valid,
    input logic               bit_out,
    input logic               done,
    input logic               go,
    input logic               all_now,
    input enc_state_e         state_q,
    input logic [NCOEF-1:0]   flags,
    input logic [PLANE_W-1:0] plane_q
);

    // R9: no stream bit while done is shown
    a_r9_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bit_valid);

    // R9: done only after the last plane
    a_r9_done_last_plane: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (plane_q == '0));

    // R6: the sign step always follows a visible significance 1
    a_r6_sign_after_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SIGN) |-> (bit_valid && bit_out));

    // R8: refinement-only mode only with every flag set
    a_r8_ref_all_sig: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REF) |-> all_now);

    // R8: refinement-only mode emits every cycle
    a_r8_ref_each_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REF) |=> bit_valid);

    // R5: significance flags never drop within one block
    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ((flags & $past(flags)) == $past(flags)));

endmodule

bind spiht_block_encoder spiht_encoder_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_out   (bit_out),
    .done      (done),
    .go        (go),
    .all_now   (all_now),
    .state_q   (state_q),
    .flags     (flags),
    .plane_q   (plane_q)
);

// File: tb/spiht_block_encoder_tb.sv
`timescale 1ns/1ps
module spiht_block_encoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic       start = 1'b0;
    logic       bit_out, bit_valid, done;

    always #4 clk = ~clk;

    spiht_block_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .bit_out(bit_out),
        .bit_valid(bit_valid), .done(done)
    );

    int checks = 0;
    int failures = 0;
    logic [7:0] mag [64];
    bit         sgn [64];
    bit         exp_q [$];
    int         vcyc [$];
    int         cyc = 0;
    int         nbits = 0;
    int         last_valid = 0;
    int         done_cyc = 0;
    bit         done_seen = 0;
    bit         prev_done = 0;
    bit         mon_on = 0;
    string      cur_tag = "";
    int unsigned seed = 32'h1234_5678;

    task automatic check_int(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int z2r(int i);
        int row, col;
        row = ((i >> 5) & 1) * 4 + ((i >> 3) & 1) * 2 + ((i >> 1) & 1);
        col = ((i >> 4) & 1) * 4 + ((i >> 2) & 1) * 2 + (i & 1);
        return row * 8 + col;
    endfunction

    function automatic bit bit_of(int i, int n);
        return mag[z2r(i)][n];
    endfunction

    function automatic int unsigned rnd();
        seed = seed * 1103515245 + 12345;
        return seed >> 8;
    endfunction

    // Behavioural model of the traversal (R3..R8)
    task automatic build_model();
        bit f [64];
        exp_q.delete();
        for (int i = 0; i < 64; i++) f[i] = 0;
        for (int n = 7; n >= 0; n--) begin
            bit all_sig = 1;
            for (int i = 0; i < 64; i++) if (!f[i]) all_sig = 0;
            if (all_sig) begin
                for (int i = 0; i < 64; i++) exp_q.push_back(bit_of(i, n));
            end else begin
                int i = 0;
                while (i < 64) begin
                    bit skip = 0;
                    if (i % 16 == 0) begin
                        bit af = 0, h = 0;
                        for (int j = i; j < i + 16; j++) begin af |= f[j]; h |= bit_of(j, n); end
                        if (!af) begin
                            exp_q.push_back(h);
                            if (!h) begin i += 16; skip = 1; end
                        end
                    end
                    if (!skip && i % 4 == 0) begin
                        bit af = 0, h = 0;
                        for (int j = i; j < i + 4; j++) begin af |= f[j]; h |= bit_of(j, n); end
                        if (!af) begin
                            exp_q.push_back(h);
                            if (!h) begin i += 4; skip = 1; end
                        end
                    end
                    if (!skip) begin
                        bit b = bit_of(i, n);
                        exp_q.push_back(b);
                        if (!f[i] && b) begin
                            exp_q.push_back(sgn[z2r(i)]);
                            f[i] = 1;
                        end
                        i++;
                    end
                end
            end
        end
    endtask

    // Per-clock comparison against the model queue
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (bit_valid) begin
                nbits++;
                vcyc.push_back(cyc);
                last_valid = cyc;
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL %s extra bit: actual=%0b expected=none", cur_tag, bit_out);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    checks++;
                    if (bit_out !== e) begin
                        failures++;
                        $display("FAIL %s stream bit %0d: actual=%0b expected=%0b",
                                 cur_tag, nbits - 1, bit_out, e);
                    end
                end
            end
            if (done && !prev_done && !done_seen) begin
                done_seen = 1;
                done_cyc  = cyc;
            end
        end
        prev_done = done;
    end

    task automatic load_block();
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = a[5:0];
            wr_data = {sgn[a], mag[a]};
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_block(string tag, bit disturb);
        int expected_len;
        build_model();
        expected_len = exp_q.size();
        vcyc.delete();
        nbits = 0;
        done_seen = 0;
        cur_tag = tag;
        mon_on = 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (disturb) begin
            // R1/R2: start and write while encoding must be ignored
            repeat (20) @(negedge clk);
            start   = 1'b1;
            wr_en   = 1'b1;
            wr_addr = 6'd0;
            wr_data = {~sgn[0], ~mag[0]};
            @(negedge clk);
            start = 1'b0;
            wr_en = 1'b0;
        end
        wait (done_seen);
        @(negedge clk);
        mon_on = 0;
        check_int(tag, "bit count", nbits, expected_len);
        check_int(tag, "unconsumed bits", exp_q.size(), 0);
        // R9: done rises the cycle after the last valid bit
        check_int({tag, "/R9"}, "done delay", done_cyc - last_valid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check_int("R9", "valid after reset", bit_valid, 0);
        check_int("R9", "done after reset", done, 0);

        // R10/R4: all-zero block
        for (int a = 0; a < 64; a++) begin mag[a] = 0; sgn[a] = 0; end
        load_block();
        run_block("R10/R4", 0);
        check_int("R10", "zero block length", nbits, 32);
        repeat (5) @(negedge clk);
        check_int("R9", "done held", done, 1);
        check_int("R9", "valid while done", bit_valid, 0);

        // R3/R6/R7: one negative pixel at row 5 col 6
        for (int a = 0; a < 64; a++) begin mag[a] = 0; sgn[a] = 0; end
        mag[5*8+6] = 8'h23; sgn[5*8+6] = 1;
        load_block();
        run_block("R3/R6/R7", 0);

        // R3/R5: sparse pseudo-random block
        for (int a = 0; a < 64; a++) begin
            int unsigned r = rnd();
            mag[a] = 8'((r & 8'hFF) >> (r % 6));
            sgn[a] = r[9];
        end
        load_block();
        run_block("R3/R5", 0);

        // R8: every magnitude reaches 128, so refinement-only after plane 7
        for (int a = 0; a < 64; a++) begin
            int unsigned r = rnd();
            mag[a] = 8'h80 | 8'(r & 8'h7F);
            sgn[a] = r[11];
        end
        load_block();
        run_block("R8", 0);
        check_int("R8", "total bits", nbits, 4 + 16 + 128 + 448);
        if (vcyc.size() >= 448)
            check_int("R8", "span of last 448 bits",
                      vcyc[vcyc.size()-1] - vcyc[vcyc.size()-448], 447);

        // R1/R2: disturbance during encode, then rerun without reload
        for (int a = 0; a < 64; a++) begin
            int unsigned r = rnd();
            mag[a] = 8'(r & 8'hFF);
            sgn[a] = r[12];
        end
        load_block();
        run_block("R1/R2", 1);
        run_block("R1", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule